// File: doc/BRIEF.md
# Banked cartridge memory mapper

This block sits between an 8-bit console CPU, its picture processor and the cartridge memories. It snoops CPU writes in the upper 32 KiB and turns them into bank-select and control registers. It then converts CPU addresses into program ROM addresses and picture-bus pattern addresses into character ROM addresses. Three 8 KiB program windows can be switched. The top program window is always tied to the last ROM bank. The 8 KiB pattern space is split into eight 1 KiB windows that can each be switched.

A control register holds two settings. Its low two bits choose how the nametables are mirrored. Its top bit opens the 8 KiB work-RAM window at 0x6000–0x7FFF. Before a write address is decoded, it is folded so that address bit 4 does the job of bit 3. The one exception is a reserved register pair in the 0x9xxx page. The CPU read-data output selects program ROM data, work-RAM data, or the open-bus value the CPU would otherwise see. The interrupt counter, audio and the memories themselves live outside this block.

Top module: `cart_bank_mapper`

## Requirements
- R1: After a synchronous reset every bank select and the control byte are zero. Mirroring therefore reads 0 (vertical), all switchable windows map to bank 0, and work RAM is disabled.
- R2: Writes to 0x8000, 0x8008 and 0x9000 set the bank for the CPU windows at 0x8000, 0xA000 and 0xC000. The low 6 bits of the data are kept and then reduced modulo 2^PRG_BANK_BITS. prg_addr is {bank, cpu_addr[12:0]}.
- R3: CPU addresses 0xE000–0xFFFF always map to the last program bank, with all bank bits set to one.
- R4: Writes to 0xA000, 0xA008, 0xB000, 0xB008, 0xC000, 0xC008, 0xD000 and 0xD008 set the 1 KiB pattern windows 0 to 7, in that order. The window is ppu_addr[12:10]. The full 8-bit value is reduced modulo 2^CHR_BANK_BITS. chr_addr is {bank, ppu_addr[9:0]}.
- R5: Address folding is applied before decoding. If bit 4 is set and (addr & 0xF010) is not 0x9010, bit 3 is set and bit 4 is cleared. The result is then masked with 0xF038. So 0x8010 reaches the 0xA000 program window, 0xA010 reaches pattern window 1, and 0xD018 reaches pattern window 7.
- R6: Folded addresses that match no register are ignored. These include 0x9010, 0x9030, 0x9018 and 0x8020. Every bank select stays unchanged after such a write.
- R7: A write to 0xE000 loads the control byte. mirror_mode equals bits 1:0: 0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper. A write that folds to 0xE008 leaves mirroring unchanged.
- R8: Control bit 7 enables work RAM. While it is clear, wram_we stays low for writes to 0x6000–0x7FFF and reads there return cpu_open_bus. While it is set, wram_we follows cpu_we there and reads return wram_rdata.
- R9: CPU reads at 0x8000 and above return prg_rdata. Reads below 0x6000 return cpu_open_bus.
- R10: Registers change only on a clock edge with cpu_we high. Address outputs are combinational, so a pattern fetch in the cycle of a bank write uses the old bank, and the new bank is used from the next cycle.
- R11: Writes below 0x8000 never change a bank select or the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_open_bus | input | 8 | Value the CPU data bus holds when nothing drives it |
| prg_rdata | input | 8 | Data from program ROM |
| wram_rdata | input | 8 | Data from work RAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| prg_addr | output | PRG_BANK_BITS+13 | Banked program ROM address |
| wram_addr | output | 13 | Work-RAM address |
| wram_we | output | 1 | Work-RAM write enable |
| ppu_addr | input | 13 | Pattern-space address from the picture bus |
| chr_addr | output | CHR_BANK_BITS+10 | Banked character ROM address |
| mirror_mode | output | 2 | Nametable mirroring selection |

## Verification
A CPU write to a pattern bank register can arrive in the same cycle that the picture bus fetches from that same window. The bench holds ppu_addr in window 2 while it writes 0xB000. It checks chr_addr during the write cycle against the old bank. It checks chr_addr again in the following cycle against the new bank. Control writes that toggle the RAM enable are also mixed with RAM writes in adjacent cycles, and wram_we is checked in each of those cycles.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam int NUM_PRG_SEL  = 3;
    localparam int NUM_CHR_SEL  = 8;
    localparam int PRG_SEL_KEEP = 6;
    localparam int CTRL_RAM_BIT = 7;

    localparam logic [15:0] FOLD_MASK  = 16'hF038;
    localparam logic [15:0] KEEP_MASK  = 16'hF010;
    localparam logic [15:0] KEEP_MATCH = 16'h9010;

    localparam logic [15:0] A_PRG0 = 16'h8000;
    localparam logic [15:0] A_PRG1 = 16'h8008;
    localparam logic [15:0] A_PRG2 = 16'h9000;
    localparam logic [15:0] A_CTRL = 16'hE000;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_PRG,
        TGT_CHR,
        TGT_CTRL
    } reg_target_e;

    typedef struct packed {
        reg_target_e target;
        logic [2:0]  idx;
        logic [7:0]  data;
    } write_op_t;

    typedef struct packed {
        logic [NUM_PRG_SEL-1:0][PRG_SEL_KEEP-1:0] prg;
        logic [NUM_CHR_SEL-1:0][7:0]              chr;
        logic [7:0]                               ctrl;
    } bank_regs_t;

    // Bit 4 stands in for bit 3 everywhere except the reserved 0x9010 pair.
    function automatic logic [15:0] cbm_fold(input logic [15:0] a);
        logic [15:0] r;
        r = a;
        if (a[4] && ((a & KEEP_MASK) != KEEP_MATCH)) begin
            r[3] = 1'b1;
            r[4] = 1'b0;
        end
        return r & FOLD_MASK;
    endfunction

    // Pattern window slot from a folded address in pages 0xA..0xD.
    function automatic logic [2:0] cbm_chr_slot(input logic [15:0] f);
        logic [3:0] page;
        page = f[15:12] - 4'hA;
        return {page[1:0], f[3]};
    endfunction

endpackage

// File: rtl/cbm_write_decode.sv
module cbm_write_decode
    import cbm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_we,
    output bank_regs_t  regs
);

    logic [15:0] folded;
    write_op_t   op;

    always_comb begin
        folded    = cbm_fold(cpu_addr);
        op.target = TGT_NONE;
        op.idx    = '0;
        op.data   = cpu_wdata;
        if (cpu_we && cpu_addr[15]) begin
            if (folded == A_PRG0) begin
                op.target = TGT_PRG;
                op.idx    = 3'd0;
            end else if (folded == A_PRG1) begin
                op.target = TGT_PRG;
                op.idx    = 3'd1;
            end else if (folded == A_PRG2) begin
                op.target = TGT_PRG;
                op.idx    = 3'd2;
            end else if (folded == A_CTRL) begin
                op.target = TGT_CTRL;
            end else if (!folded[5] && !folded[4] &&
                         folded[15:12] >= 4'hA && folded[15:12] <= 4'hD) begin
                op.target = TGT_CHR;
                op.idx    = cbm_chr_slot(folded);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            case (op.target)
                TGT_PRG:  regs.prg[op.idx[1:0]] <= op.data[PRG_SEL_KEEP-1:0];
                TGT_CHR:  regs.chr[op.idx]      <= op.data;
                TGT_CTRL: regs.ctrl             <= op.data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
    import cbm_pkg::*;
#(
    parameter int PRG_BANK_BITS = 5
) (
    input  bank_regs_t                 regs,
    input  logic [15:0]                cpu_addr,
    output logic [PRG_BANK_BITS+12:0]  prg_addr
);

    logic [PRG_SEL_KEEP-1:0]  sel;
    logic                     fixed_top;
    logic [PRG_BANK_BITS-1:0] sel_fit;
    logic [PRG_BANK_BITS-1:0] bank;

    always_comb begin
        fixed_top = 1'b0;
        case (cpu_addr[14:13])
            2'd0:    sel = regs.prg[0];
            2'd1:    sel = regs.prg[1];
            2'd2:    sel = regs.prg[2];
            default: begin
                sel       = '0;
                fixed_top = 1'b1;
            end
        endcase
    end

    generate
        if (PRG_BANK_BITS <= PRG_SEL_KEEP) begin : g_trunc
            assign sel_fit = sel[PRG_BANK_BITS-1:0];
        end else begin : g_extend
            assign sel_fit = {{(PRG_BANK_BITS-PRG_SEL_KEEP){1'b0}}, sel};
        end
    endgenerate

    assign bank     = fixed_top ? '1 : sel_fit;
    assign prg_addr = {bank, cpu_addr[12:0]};

endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
    import cbm_pkg::*;
#(
    parameter int CHR_BANK_BITS = 7
) (
    input  bank_regs_t                regs,
    input  logic [12:0]               ppu_addr,
    output logic [CHR_BANK_BITS+9:0]  chr_addr
);

    logic [7:0]               sel;
    logic [CHR_BANK_BITS-1:0] bank;

    assign sel = regs.chr[ppu_addr[12:10]];

    generate
        if (CHR_BANK_BITS <= 8) begin : g_trunc
            assign bank = sel[CHR_BANK_BITS-1:0];
        end else begin : g_extend
            assign bank = {{(CHR_BANK_BITS-8){1'b0}}, sel};
        end
    endgenerate

    assign chr_addr = {bank, ppu_addr[9:0]};

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int PRG_BANK_BITS = 5,
    parameter int CHR_BANK_BITS = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [15:0]                cpu_addr,
    input  logic [7:0]                 cpu_wdata,
    input  logic                       cpu_we,
    input  logic [7:0]                 cpu_open_bus,
    input  logic [7:0]                 prg_rdata,
    input  logic [7:0]                 wram_rdata,
    output logic [7:0]                 cpu_rdata,
    output logic [PRG_BANK_BITS+12:0]  prg_addr,
    output logic [12:0]                wram_addr,
    output logic                       wram_we,
    input  logic [12:0]                ppu_addr,
    output logic [CHR_BANK_BITS+9:0]   chr_addr,
    output logic [1:0]                 mirror_mode
);

    localparam logic [2:0] WRAM_PAGE = 3'b011;

    bank_regs_t regs;
    logic       wram_hit;
    logic       wram_on;
    mirror_e    mir;

    cbm_write_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .regs      (regs)
    );

    cbm_prg_map #(.PRG_BANK_BITS(PRG_BANK_BITS)) u_prg (
        .regs     (regs),
        .cpu_addr (cpu_addr),
        .prg_addr (prg_addr)
    );

    cbm_chr_map #(.CHR_BANK_BITS(CHR_BANK_BITS)) u_chr (
        .regs     (regs),
        .ppu_addr (ppu_addr),
        .chr_addr (chr_addr)
    );

    assign wram_hit  = (cpu_addr[15:13] == WRAM_PAGE);
    assign wram_on   = regs.ctrl[CTRL_RAM_BIT];
    assign wram_addr = cpu_addr[12:0];
    assign wram_we   = cpu_we && wram_hit && wram_on;

    always_comb begin
        if (cpu_addr[15])
            cpu_rdata = prg_rdata;
        else if (wram_hit && wram_on)
            cpu_rdata = wram_rdata;
        else
            cpu_rdata = cpu_open_bus;
    end

    assign mir         = mirror_e'(regs.ctrl[1:0]);
    assign mirror_mode = mir;

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
    parameter int PRG_BANK_BITS = 5,
    parameter int CHR_BANK_BITS = 7
) (
    input logic                       clk,
    input logic                       rst,
    input logic [15:0]                cpu_addr,
    input logic [7:0]                 cpu_wdata,
    input logic                       cpu_we,
    input logic [7:0]                 cpu_open_bus,
    input logic [7:0]                 prg_rdata,
    input logic [7:0]                 wram_rdata,
    input logic [7:0]                 cpu_rdata,
    input logic [PRG_BANK_BITS+12:0]  prg_addr,
    input logic [12:0]                wram_addr,
    input logic                       wram_we,
    input logic [12:0]                ppu_addr,
    input logic [CHR_BANK_BITS+9:0]   chr_addr,
    input logic [1:0]                 mirror_mode
);

    logic reg_write;
    assign reg_write = cpu_we && cpu_addr[15];

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (mirror_mode == 2'd0) && !wram_we);

    a_r3_top_fixed: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b111) |-> (prg_addr[PRG_BANK_BITS+12:13] == '1));

    a_r8_ram_gate: assert property (@(posedge clk) disable iff (rst)
        wram_we |-> (cpu_we && cpu_addr[15:13] == 3'b011));

    a_r9_low_open_bus: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] < 3'b011) |-> (cpu_rdata == cpu_open_bus));

    a_r10_mirror_holds: assert property (@(posedge clk) disable iff (rst)
        !reg_write |=> $stable(mirror_mode));

    a_r10_chr_holds: assert property (@(posedge clk) disable iff (rst)
        !reg_write |=> ($stable(ppu_addr) -> $stable(chr_addr)));

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
    .PRG_BANK_BITS(PRG_BANK_BITS),
    .CHR_BANK_BITS(CHR_BANK_BITS)
) chk_i (.*);

// File: tb/cart_bank_mapper_tb_top.sv
module cart_bank_mapper_tb_top;

    localparam int CLK_P = 10;
    localparam int PB    = 5;
    localparam int CB    = 7;

    localparam int K_PRG = 0;
    localparam int K_CHR = 1;
    localparam int K_RD  = 2;
    localparam int K_MIR = 3;
    localparam int K_WE  = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_we = 1'b0;
    logic [7:0]        cpu_open_bus = 8'hAB;
    logic [7:0]        prg_rdata = 8'hC3;
    logic [7:0]        wram_rdata = 8'h55;
    logic [7:0]        cpu_rdata;
    logic [PB+12:0]    prg_addr;
    logic [12:0]       wram_addr;
    logic              wram_we;
    logic [12:0]       ppu_addr = '0;
    logic [CB+9:0]     chr_addr;
    logic [1:0]        mirror_mode;

    item_t sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cart_bank_mapper #(.PRG_BANK_BITS(PB), .CHR_BANK_BITS(CB)) dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_open_bus(cpu_open_bus), .prg_rdata(prg_rdata),
        .wram_rdata(wram_rdata), .cpu_rdata(cpu_rdata), .prg_addr(prg_addr),
        .wram_addr(wram_addr), .wram_we(wram_we), .ppu_addr(ppu_addr),
        .chr_addr(chr_addr), .mirror_mode(mirror_mode)
    );

    function automatic logic [31:0] pexp(input int bank, input logic [15:0] a);
        logic [PB-1:0] b;
        b = PB'(bank);
        return 32'({b, a[12:0]});
    endfunction

    function automatic logic [31:0] cexp(input int bank, input logic [12:0] pa);
        logic [CB-1:0] b;
        b = CB'(bank);
        return 32'({b, pa[9:0]});
    endfunction

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(posedge clk);
    endtask

    task automatic wr_chk(input logic [15:0] a, input logic [7:0] d, input logic [12:0] pa,
                          input int kind, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; ppu_addr = pa;
        push(kind, exp, tag);
        @(posedge clk);
    endtask

    task automatic chk(input logic [15:0] a, input logic [12:0] pa,
                       input int kind, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_we = 1'b0; ppu_addr = pa;
        push(kind, exp, tag);
        @(posedge clk);
    endtask

    // Monitor: pops expectations and compares them a quarter period after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_PRG:   act = 32'(prg_addr);
                    K_CHR:   act = 32'(chr_addr);
                    K_RD:    act = 32'(cpu_rdata);
                    K_MIR:   act = 32'(mirror_mode);
                    default: act = 32'(wram_we);
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(16'h8123, 13'h0000, K_PRG, pexp(0, 16'h8123), "R1 prg window0");
        chk(16'h8000, 13'h0C05, K_CHR, cexp(0, 13'h0C05), "R1 chr window3");
        chk(16'h8000, 13'h0000, K_MIR, 32'd0, "R1 mirror vertical");
        chk(16'h6010, 13'h0000, K_RD, 32'hAB, "R1 ram disabled read");
        wr_chk(16'h6000, 8'h12, 13'h0, K_WE, 32'd0, "R1 ram disabled write");

        // R2: switchable program windows
        wr(16'h8000, 8'h07);
        chk(16'h8123, 13'h0, K_PRG, pexp(7, 16'h8123), "R2 window 0x8000");
        wr(16'h8008, 8'h05);
        chk(16'hA000, 13'h0, K_PRG, pexp(5, 16'hA000), "R2 window 0xA000");
        wr(16'h9000, 8'h03);
        chk(16'hC456, 13'h0, K_PRG, pexp(3, 16'hC456), "R2 window 0xC000");
        wr(16'h8000, 8'hFF);
        chk(16'h9FFF, 13'h0, K_PRG, pexp(31, 16'h9FFF), "R2 oversize wraps");

        // R3: fixed top window
        chk(16'hE000, 13'h0, K_PRG, pexp(31, 16'hE000), "R3 top window start");
        chk(16'hFFFF, 13'h0, K_PRG, pexp(31, 16'hFFFF), "R3 top window end");

        // R4: pattern windows in order
        for (int i = 0; i < 8; i++) begin
            wr(16'(16'hA000 + (i / 2) * 16'h1000 + (i % 2) * 8), 8'(8'h10 + i));
        end
        for (int i = 0; i < 8; i++) begin
            chk(16'h8000, 13'(i * 13'h400 + 13'h3A), K_CHR,
                cexp(16 + i, 13'(i * 13'h400 + 13'h3A)), "R4 window order");
        end
        wr(16'hA000, 8'hFF);
        chk(16'h8000, 13'h0001, K_CHR, cexp(127, 13'h0001), "R4 oversize wraps");

        // R5: folding of bit 4 onto bit 3
        wr(16'h8010, 8'h09);
        chk(16'hA010, 13'h0, K_PRG, pexp(9, 16'hA010), "R5 0x8010 to program window 1");
        wr(16'hA010, 8'h22);
        chk(16'h8000, 13'h0401, K_CHR, cexp(8'h22, 13'h0401), "R5 0xA010 to pattern window 1");
        wr(16'hD018, 8'h33);
        chk(16'h8000, 13'h1C02, K_CHR, cexp(8'h33, 13'h1C02), "R5 0xD018 to pattern window 7");

        // R6: unmatched folded addresses are ignored
        wr(16'h9010, 8'h11);
        wr(16'h9030, 8'h12);
        wr(16'h9018, 8'h13);
        wr(16'h8020, 8'h14);
        chk(16'hC000, 13'h0, K_PRG, pexp(3, 16'hC000), "R6 window 0xC000 kept");
        chk(16'h8000, 13'h0, K_PRG, pexp(31, 16'h8000), "R6 window 0x8000 kept");
        chk(16'hA000, 13'h0, K_PRG, pexp(9, 16'hA000), "R6 window 0xA000 kept");

        // R10: bank write and pattern fetch in the same cycle
        wr_chk(16'hB000, 8'h44, 13'h08AB, K_CHR, cexp(8'h12, 13'h08AB), "R10 old bank in write cycle");
        chk(16'h8000, 13'h08AB, K_CHR, cexp(8'h44, 13'h08AB), "R10 new bank next cycle");

        // R7: mirroring
        wr(16'hE000, 8'h01);
        chk(16'h8000, 13'h0, K_MIR, 32'd1, "R7 horizontal");
        wr(16'hE000, 8'h02);
        chk(16'h8000, 13'h0, K_MIR, 32'd2, "R7 single lower");
        wr(16'hE000, 8'h03);
        chk(16'h8000, 13'h0, K_MIR, 32'd3, "R7 single upper");
        wr(16'hE010, 8'h00);
        chk(16'h8000, 13'h0, K_MIR, 32'd3, "R7 0xE008 leaves mirroring");
        wr(16'hE000, 8'h00);
        chk(16'h8000, 13'h0, K_MIR, 32'd0, "R7 vertical");

        // R8: work RAM gating
        wr_chk(16'h6123, 8'h99, 13'h0, K_WE, 32'd0, "R8 write dropped when disabled");
        chk(16'h7FFF, 13'h0, K_RD, 32'hAB, "R8 read open bus when disabled");
        wr(16'hE000, 8'h80);
        wr_chk(16'h6123, 8'h99, 13'h0, K_WE, 32'd1, "R8 write passes when enabled");
        chk(16'h6123, 13'h0, K_RD, 32'h55, "R8 read ram when enabled");
        chk(16'h6123, 13'h0, K_MIR, 32'd0, "R8 mirror with ram on");
        wr(16'hE000, 8'h81);
        wr_chk(16'h7FFE, 8'h01, 13'h0, K_WE, 32'd1, "R8 ram stays on");
        wr(16'hE000, 8'h01);
        wr_chk(16'h7FFE, 8'h01, 13'h0, K_WE, 32'd0, "R8 ram off again");
        wr(16'hE000, 8'h81);

        // R9: read source selection
        chk(16'h5FFF, 13'h0, K_RD, 32'hAB, "R9 below ram window");
        chk(16'h9000, 13'h0, K_RD, 32'hC3, "R9 program rom");

        // R11: low writes leave registers alone
        wr(16'h7000, 8'h00);
        wr(16'h0000, 8'hFF);
        wr(16'h1008, 8'h02);
        chk(16'h8000, 13'h0, K_PRG, pexp(31, 16'h8000), "R11 window 0x8000");
        chk(16'hA000, 13'h0, K_PRG, pexp(9, 16'hA000), "R11 window 0xA000");
        chk(16'h8000, 13'h0, K_MIR, 32'd1, "R11 mirror kept");
        chk(16'h8000, 13'h1C00, K_CHR, cexp(8'h33, 13'h1C00), "R11 pattern window 7");

        // R1: reset mid-run
        @(negedge clk);
        cpu_we = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(16'h8000, 13'h0, K_MIR, 32'd0, "R1 mirror after reset");
        chk(16'hA000, 13'h0, K_PRG, pexp(0, 16'hA000), "R1 program after reset");
        chk(16'h8000, 13'h1C00, K_CHR, cexp(0, 13'h1C00), "R1 pattern after reset");
        chk(16'h6000, 13'h0, K_RD, 32'hAB, "R1 ram off after reset");

        @(negedge clk);
        #(CLK_P/2);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule